// File: doc/BRIEF.md
# UART Receive Error Status Capture

This block is the receive-side status path of a UART. An upstream deserialiser, which is not part of this block, hands over each received character with three error tags: framing, parity and break. The block stores the character and its tags together in a receive FIFO. Software reads characters through a data register on a simple register port. Each data read pops one entry and returns the character, its tags and the current overrun flag in one word.

A status register holds the framing, parity and break flags of the character most recently popped. It also holds a live overrun flag, which is set in the cycle an arriving character finds the FIFO full. A write to the status offset clears all four flags, whatever data is written. Reads and writes use separate address and enable lines, so a data pop and a clear can fall in the same cycle.

Top module: `uart_rx_errstat`

## Requirements
- R1: After reset all four status flags are 0, the FIFO is empty and rd_data is 0.
- R2: A read at offset 0x0 with the FIFO not empty pops the oldest entry. rd_data then carries the character in bits 7:0, its framing tag in bit 8, its parity tag in bit 9, its break tag in bit 10, and in bit 11 the overrun flag as it stood before the read. Characters come out in arrival order.
- R3: A read at offset 0x4 returns the flags held before the read: framing in bit 0, parity in bit 1, break in bit 2 and overrun in bit 3. Bits 31:4 are 0.
- R4: The framing, parity and break flags change only on a data-register pop or a clear. On a pop they take that character's tags.
- R5: A push while the FIFO holds DEPTH (16) entries sets the overrun flag at that clock edge. The character is discarded and the stored entries are kept. Fullness is judged before any pop in the same cycle.
- R6: A write at offset 0x4 clears all four flags, whatever value is on wr_data.
- R7: A read at offset 0x0 with the FIFO empty returns 0 and leaves all four flags unchanged. A push in the same cycle is stored.
- R8: When a data pop and a clear fall in the same cycle, overrun ends at 0 and framing, parity and break take the popped character's tags.
- R9: When an overrun push and a clear fall in the same cycle, the overrun flag ends at 1.
- R10: rd_data is registered. It updates at the clock edge that samples rd_en and otherwise holds. A read at any offset other than 0x0 or 0x4 returns 0. A write at any offset other than 0x4 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | A received character is offered this cycle |
| push_char | input | 8 | Received character |
| push_frm | input | 1 | Framing error tag of the character |
| push_par | input | 1 | Parity error tag of the character |
| push_brk | input | 1 | Break tag of the character |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W (4) | Read byte offset |
| rd_data | output | BUS_W (32) | Registered read data |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Write byte offset |
| wr_data | input | BUS_W (32) | Write data, ignored by the clear |

## Verification
The assertions assume that every input is a defined 0 or 1 at each sampling edge and that push_valid is honoured in any cycle, with no back-pressure. They also assume that the read and write strobes are single-cycle qualifiers, so a strobe held high for two cycles means two accesses. The stimulus drives all inputs on the falling edge from one task, so each value is defined and stable at the rising edge. The random mix uses mostly the two mapped offsets, with a small share of unmapped ones. Push bursts are long enough to fill the FIFO and trigger overrun, and clear writes are rare enough that latched flags stay visible between them.

// File: rtl/uart_rx_errstat_pkg.sv
package uart_rx_errstat_pkg;
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic brk;
    logic par;
    logic frm;
  } rx_tags_t;

  // Packed layout: bit 10 brk, bit 9 par, bit 8 frm, bits 7:0 character
  typedef struct packed {
    rx_tags_t            tags;
    logic [CHAR_W-1:0]   ch;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);
endpackage

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
  import uart_rx_errstat_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      push,
  input  rx_entry_t push_entry,
  input  logic      pop,
  output rx_entry_t head,
  output logic      full,
  output logic      empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  rx_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  // Storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_entry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  p_full_keeps_r5: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> full);

  p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/rx_err_status.sv
module rx_err_status
  import uart_rx_errstat_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     pop_fire,
  input  rx_tags_t pop_tags,
  input  logic     ovr_event,
  input  logic     clr,
  output rx_tags_t tags_q,
  output logic     ovr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tags_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      // A pop beats a clear for the latched tags
      if (pop_fire)  tags_q <= pop_tags;
      else if (clr)  tags_q <= '0;
      // A fresh overrun beats a clear
      if (ovr_event) ovr_q  <= 1'b1;
      else if (clr)  ovr_q  <= 1'b0;
    end
  end

  p_tags_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!pop_fire && !clr) |=> $stable(tags_q));

  p_tags_follow_r4: assert property (@(posedge clk) disable iff (rst)
    pop_fire |=> (tags_q == $past(pop_tags)));

  p_ovr_set_r5: assert property (@(posedge clk) disable iff (rst)
    ovr_event |=> ovr_q);

  p_clear_all_r6: assert property (@(posedge clk) disable iff (rst)
    (clr && !pop_fire && !ovr_event) |=> (tags_q == '0 && !ovr_q));

  p_pop_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (pop_fire && clr && !ovr_event) |=> !ovr_q);

  p_ovr_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (ovr_event && clr) |=> ovr_q);
endmodule

// File: rtl/uart_rx_errstat.sv
module uart_rx_errstat
  import uart_rx_errstat_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [CHAR_W-1:0] push_char,
  input  logic              push_frm,
  input  logic              push_par,
  input  logic              push_brk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BUS_W-1:0]  rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BUS_W-1:0]  wr_data
);
  localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(4);

  rx_entry_t push_entry, head;
  rx_tags_t  tags_q;
  logic      full, empty, ovr_q;
  logic      rd_data_hit, rd_stat_hit, pop, clr, ovr_event;
  logic [BUS_W-1:0] rd_word;

  assign push_entry = '{tags: '{brk: push_brk, par: push_par, frm: push_frm},
                        ch: push_char};
  assign rd_data_hit = rd_en && (rd_addr == OFS_DATA);
  assign rd_stat_hit = rd_en && (rd_addr == OFS_STAT);
  assign pop         = rd_data_hit && !empty;
  assign clr         = wr_en && (wr_addr == OFS_STAT);
  assign ovr_event   = push_valid && full;

  rx_tag_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst        (rst),
    .push       (push_valid),
    .push_entry (push_entry),
    .pop        (pop),
    .head       (head),
    .full       (full),
    .empty      (empty)
  );

  rx_err_status u_status (
    .clk       (clk),
    .rst       (rst),
    .pop_fire  (pop),
    .pop_tags  (head.tags),
    .ovr_event (ovr_event),
    .clr       (clr),
    .tags_q    (tags_q),
    .ovr_q     (ovr_q)
  );

  always_comb begin
    rd_word = '0;
    if (pop)
      rd_word = BUS_W'({ovr_q, head});
    else if (rd_stat_hit)
      rd_word = BUS_W'({ovr_q, tags_q.brk, tags_q.par, tags_q.frm});
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_word;
  end

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr != OFS_DATA && rd_addr != OFS_STAT) |=> (rd_data == '0));

  p_stat_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
    rd_stat_hit |=> (rd_data[BUS_W-1:4] == '0));

  p_empty_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_data_hit && empty) |=> (rd_data == '0));

  p_clear_any_data_r6: assert property (@(posedge clk) disable iff (rst)
    (clr && wr_data != '0 && !pop && !ovr_event) |=> (tags_q == '0 && !ovr_q));
endmodule

// File: tb/sim_uart_rx_errstat.sv
module sim_uart_rx_errstat;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        push_valid;
  logic [7:0]  push_char;
  logic        push_frm, push_par, push_brk;
  logic        rd_en, wr_en;
  logic [3:0]  rd_addr, wr_addr;
  logic [31:0] rd_data, wr_data;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // Reference model state
  logic [10:0] mq [$];
  logic        m_frm, m_par, m_brk, m_ovr;

  always #2.5 clk = ~clk;

  uart_rx_errstat u0 (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_char(push_char),
    .push_frm(push_frm), .push_par(push_par), .push_brk(push_brk),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [31:0] status_word();
    return {28'b0, m_ovr, m_brk, m_par, m_frm};
  endfunction

  function automatic logic [31:0] expect_read(logic [3:0] a);
    if (a == 4'h0) return (mq.size() == 0) ? 32'b0 : {20'b0, m_ovr, mq[0]};
    if (a == 4'h4) return status_word();
    return 32'b0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, update model, sample after posedge
  task automatic step(string req, bit p, logic [7:0] ch, logic [2:0] tg,
                      bit rd, logic [3:0] ra, bit wr, logic [3:0] wa,
                      logic [31:0] wd);
    logic [31:0] exp;
    bit full, popped, clr;
    @(negedge clk);
    push_valid = p; push_char = ch;
    {push_brk, push_par, push_frm} = tg;
    rd_en = rd; rd_addr = ra; wr_en = wr; wr_addr = wa; wr_data = wd;
    exp    = expect_read(ra);
    full   = (mq.size() == DEPTH);
    popped = rd && ra == 4'h0 && mq.size() != 0;
    clr    = wr && wa == 4'h4;
    if (popped) begin
      {m_brk, m_par, m_frm} = mq[0][10:8];
      void'(mq.pop_front());
    end else if (clr) begin
      {m_brk, m_par, m_frm} = 3'b0;
    end
    if (p && full) m_ovr = 1'b1;
    else if (clr)  m_ovr = 1'b0;
    if (p && !full) mq.push_back({tg, ch});
    @(posedge clk);
    #1;
    if (rd) check(req, rd_data, exp);
    push_valid = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic idle_read(string req, logic [3:0] a);
    step(req, 0, 8'h00, 3'b000, 1, a, 0, 4'h0, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; push_valid = 0; push_char = 0;
    push_frm = 0; push_par = 0; push_brk = 0;
    rd_en = 0; wr_en = 0; rd_addr = 0; wr_addr = 0; wr_data = 0;
    m_frm = 0; m_par = 0; m_brk = 0; m_ovr = 0;
    repeat (4) @(posedge clk);
    #1;
    check("R1", rd_data, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state seen through the bus
    idle_read("R1", 4'h4);
    idle_read("R1", 4'h0);

    // R4: pushes alone leave the latched tags at zero
    step("R4", 1, 8'hA5, 3'b001, 0, 4'h0, 0, 4'h0, 0);
    step("R4", 1, 8'h3C, 3'b110, 0, 4'h0, 0, 4'h0, 0);
    step("R4", 1, 8'h7E, 3'b010, 0, 4'h0, 0, 4'h0, 0);
    idle_read("R4", 4'h4);
    // R2: popped word layout and order; R4: tags latch on pop
    idle_read("R2", 4'h0);
    idle_read("R4", 4'h4);
    idle_read("R2", 4'h0);
    idle_read("R4", 4'h4);
    idle_read("R2", 4'h0);
    idle_read("R3", 4'h4);

    // R5: fill, overflow, then drain keeps the first DEPTH characters
    for (int i = 0; i < DEPTH + 3; i++)
      step("R5", 1, 8'(i + 8'h40), 3'(i), 0, 4'h0, 0, 4'h0, 0);
    idle_read("R5", 4'h4);
    // R5: pop and full push in one cycle, push still discarded
    step("R5", 1, 8'hEE, 3'b111, 1, 4'h0, 0, 4'h0, 0);
    for (int i = 0; i < DEPTH; i++) idle_read("R5", 4'h0);

    // R6: clear with arbitrary data
    step("R6", 0, 0, 0, 0, 4'h0, 1, 4'h4, 32'hDEAD_BEEF);
    idle_read("R6", 4'h4);

    // R7: empty read after setting flags
    step("R7", 1, 8'h11, 3'b101, 0, 4'h0, 0, 4'h0, 0);
    idle_read("R7", 4'h0);
    idle_read("R7", 4'h0);
    idle_read("R7", 4'h4);
    // R7: empty read plus push stores the push
    step("R7", 1, 8'h22, 3'b011, 1, 4'h0, 0, 4'h0, 0);
    idle_read("R7", 4'h0);

    // R8: pop and clear in one cycle after forcing overrun
    for (int i = 0; i < DEPTH + 1; i++)
      step("R8", 1, 8'(i), 3'b100, 0, 4'h0, 0, 4'h0, 0);
    step("R8", 0, 0, 0, 1, 4'h0, 1, 4'h4, 32'h1);
    idle_read("R8", 4'h4);

    // R9: overrun push and clear in one cycle
    step("R9", 1, 8'h99, 3'b000, 0, 4'h0, 0, 4'h0, 0);
    step("R9", 1, 8'h9A, 3'b000, 0, 4'h0, 1, 4'h4, 32'h0);
    idle_read("R9", 4'h4);

    // R10: unmapped read, write to data offset ignored, rd_data holds
    idle_read("R10", 4'h8);
    step("R10", 0, 0, 0, 0, 4'h0, 1, 4'h0, 32'hFFFF_FFFF);
    step("R10", 0, 0, 0, 0, 4'h0, 1, 4'hC, 32'hFFFF_FFFF);
    idle_read("R10", 4'h4);
    step("R10", 0, 0, 0, 0, 4'h0, 0, 4'h0, 0);
    check("R10", rd_data, status_word());

    // Random mix: R2/R3 bulk behaviour
    for (int n = 0; n < 4000; n++) begin
      automatic bit         p  = (($urandom % 100) < ((n / 200) % 2 ? 70 : 30));
      automatic bit         rd = (($urandom % 100) < 40);
      automatic int         s  = $urandom % 10;
      automatic logic [3:0] ra = (s < 6) ? 4'h0 : (s < 9) ? 4'h4 : 4'(($urandom % 4) * 4);
      automatic bit         wr = (($urandom % 100) < 4);
      automatic logic [3:0] wa = (($urandom % 4) == 0) ? 4'h0 : 4'h4;
      step(ra == 4'h4 ? "R3" : "R2", p, 8'($urandom), 3'($urandom),
           rd, ra, wr, wa, $urandom);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule